// File: doc/BRIEF.md
# Dual-Mode 4:2:2 Video Output Formatter

This block turns a stream of 4:2:2 pixels into a timed video output with line and field timing. Each pixel arrives on a valid/ready input as one luma byte and one chroma byte. The chroma bytes alternate Cb and Cr in the order the source sends them, and the block does not reorder them. A single timing core counts clocks of the 27 MHz video clock. It produces the horizontal reference, the vertical reference and composite sync for either the 525-line or the 625-line standard. One pixel is taken every two clocks, in both output modes.

In parallel (16-bit) mode, luma appears on `y_out` and chroma appears on `uv_out`. Each pixel is held for two clocks, and a half-rate qualifier marks the clock in which each new pixel starts. In multiplexed (8-bit) mode, `y_out` carries a byte stream: the chroma byte, then the luma byte, for every pixel. Four-byte timing reference codes surround the active window of every line, and `uv_out` is parked at 00h.

Back-pressure: `pix_ready` is high only in the clock where the block can present a new pixel. A pixel is consumed only in a clock where `pix_valid` and `pix_ready` are both high, and the block never stalls its raster. If the source is not valid in a ready clock, that pixel slot shows black (Y 10h, C 80h) and the source keeps its data for a later slot.

Top module: `vid_out_fmt`

## Requirements
- R1: In 16-bit mode, an accepted pixel shows its luma on `y_out` and its chroma on `uv_out` for the two clocks that start one clock after acceptance.
- R2: In 8-bit mode, an accepted pixel appears on `y_out` as its chroma byte, one clock after acceptance, and then as its luma byte in the following clock. `uv_out` is 00h throughout 8-bit mode.
- R3: A line lasts LINE_525 or LINE_625 clocks. `csync_n` falls at the first clock of the line. `href` rises SOA_525 or SOA_625 clocks after that fall and stays high for exactly 2*NPIX clocks.
- R4: A field has FIELD_525 or FIELD_625 lines, and two fields make a frame. `vsync` is high for the first VBL_525 or VBL_625 lines of each field.
- R5: `csync_n` is low for the first SYNC_W clocks of an ordinary line. On the first BROAD lines of each field it is low for the whole line except its last SYNC_W clocks.
- R6: `cref` toggles every clock. It is high in the clocks where a new pixel slot begins on the outputs.
- R7: In 8-bit mode, the four clocks just before `href` rises carry FF, 00, 00, XY on `y_out`, and the four clocks just after `href` falls carry the same pattern. XY is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. F is the field index, V is the `vsync` level of the line, and H is 0 before the window and 1 after it.
- R8: In blanking, 8-bit mode outputs 80h in clocks where `cref` is high and 10h in the others. 16-bit mode outputs Y 10h and UV 80h in blanking.
- R9: `pix_ready` is high only in the first clock of each pixel slot in the active window, and never on vertical blanking lines. A ready slot without `pix_valid` shows black (Y 10h, C 80h). On vertical blanking lines the window carries blanking values.
- R10: The line standard input (`std_625`: 0 selects 525, 1 selects 625) and the mode input (`mode_8bit`) are sampled only in the last clock of a frame. They take effect from the next frame.
- R11: Reset holds `y_out` at 10h, `uv_out` at 80h, `href`, `vsync`, `cref` and `pix_ready` low, and `csync_n` high. The first frame after reset runs in 525-line, 16-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_625 | input | 1 | Line standard for the next frame: 0 = 525, 1 = 625 |
| mode_8bit | input | 1 | Output mode for the next frame: 0 = 16-bit, 1 = 8-bit multiplex |
| pix_valid | input | 1 | Source offers a pixel |
| pix_ready | output | 1 | Block takes a pixel in this clock |
| pix_y | input | 8 | Luma byte of the offered pixel |
| pix_c | input | 8 | Chroma byte (Cb or Cr) of the offered pixel |
| y_out | output | 8 | Luma bus (16-bit mode) or multiplexed byte bus (8-bit mode) |
| uv_out | output | 8 | Chroma bus in 16-bit mode, 00h in 8-bit mode |
| cref | output | 1 | Half-rate pixel qualifier |
| href | output | 1 | High during the active part of each line |
| vsync | output | 1 | High during vertical blanking lines |
| csync_n | output | 1 | Composite sync, active low |

## Verification
Two functions can fall in the same cycle. The first is the end of a frame, where the new standard and mode are sampled. The second is output formatting, whose bytes and codes in the last clock of a frame still belong to the old mode. The bench changes `std_625` and `mode_8bit` in the middle of frames and switches in both directions, so that a frame edge sees a mode change and a standard change together. A behavioural model checks every clock that the first line of the new frame uses the new line length and byte format, while the frame before it keeps the old ones. A second overlap is a missing pixel in a ready slot next to a timing code: the source drops `pix_valid` on a fixed pattern that lands on the first and last slots of a window. The model expects black in those slots and the exact code bytes around them.

// File: rtl/vid_out_fmt_pkg.sv
package vid_out_fmt_pkg;

  localparam logic [7:0] BLK_Y = 8'h10;
  localparam logic [7:0] BLK_C = 8'h80;

  typedef enum logic [1:0] {
    SEG_BLANK,
    SEG_START,
    SEG_ACTIVE,
    SEG_END
  } seg_t;

  // Timing reference byte: fixed 1, field, vertical, horizontal, then protection.
  function automatic logic [7:0] trs_byte(input logic f, input logic v, input logic h);
    trs_byte = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vid_out_timing.sv
module vid_out_timing
  import vid_out_fmt_pkg::*;
#(
  parameter int NPIX       = 720,
  parameter int LINE_525   = 1716,
  parameter int LINE_625   = 1728,
  parameter int SOA_525    = 244,
  parameter int SOA_625    = 264,
  parameter int FIELD_525  = 262,
  parameter int FIELD_625  = 312,
  parameter int VBL_525    = 20,
  parameter int VBL_625    = 24,
  parameter int BROAD      = 3,
  parameter int SYNC_W     = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       std_625,
  input  logic       mode_8bit,
  output seg_t       seg,
  output logic [1:0] code_idx,
  output logic       phase,
  output logic       vblank,
  output logic       field,
  output logic       sync_low,
  output logic       mode_r
);

  localparam int HMAX = (LINE_625 > LINE_525) ? LINE_625 : LINE_525;
  localparam int LMAX = (FIELD_625 > FIELD_525) ? FIELD_625 : FIELD_525;
  localparam int HW   = $clog2(HMAX + 1);
  localparam int LW   = $clog2(LMAX + 1);
  localparam int WIN  = 2 * NPIX;

  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt;
  logic          std_r;

  int h, l, line_len, soa, act_end, flines, vbl;
  logic end_line, end_field, end_frame;

  always_comb begin
    h        = int'(hcnt);
    l        = int'(lcnt);
    line_len = std_r ? LINE_625 : LINE_525;
    soa      = std_r ? SOA_625 : SOA_525;
    flines   = std_r ? FIELD_625 : FIELD_525;
    vbl      = std_r ? VBL_625 : VBL_525;
    act_end  = soa + WIN;
    end_line  = (h == line_len - 1);
    end_field = end_line && (l == flines - 1);
    end_frame = end_field && field;

    if (h >= soa - 4 && h < soa) begin
      seg      = SEG_START;
      code_idx = 2'(h - (soa - 4));
    end else if (h >= soa && h < act_end) begin
      seg      = SEG_ACTIVE;
      code_idx = 2'd0;
    end else if (h >= act_end && h < act_end + 4) begin
      seg      = SEG_END;
      code_idx = 2'(h - act_end);
    end else begin
      seg      = SEG_BLANK;
      code_idx = 2'd0;
    end

    phase    = hcnt[0];
    vblank   = (l < vbl);
    sync_low = (l < BROAD) ? (h < line_len - SYNC_W) : (h < SYNC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      lcnt   <= '0;
      field  <= 1'b0;
      std_r  <= 1'b0;
      mode_r <= 1'b0;
    end else begin
      hcnt <= end_line ? '0 : hcnt + 1'b1;
      if (end_field) begin
        lcnt  <= '0;
        field <= ~field;
      end else if (end_line) begin
        lcnt <= lcnt + 1'b1;
      end
      if (end_frame) begin
        std_r  <= std_625;
        mode_r <= mode_8bit;
      end
    end
  end

endmodule

// File: rtl/vid_out_pixel.sv
module vid_out_pixel
  import vid_out_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seg_t       seg,
  input  logic [1:0] code_idx,
  input  logic       phase,
  input  logic       vblank,
  input  logic       field,
  input  logic       sync_low,
  input  logic       mode_r,
  input  logic       pix_valid,
  input  logic [7:0] pix_y,
  input  logic [7:0] pix_c,
  output logic       pix_ready,
  output logic [7:0] y_out,
  output logic [7:0] uv_out,
  output logic       cref,
  output logic       href,
  output logic       vsync,
  output logic       csync_n
);

  logic [7:0] y_hold, y_nx, uv_nx, hold_nx, take_y, take_c, code_b;
  logic       take, show_pix;

  always_comb begin
    pix_ready = (seg == SEG_ACTIVE) && !phase && !vblank;
    take      = pix_ready && pix_valid;
    take_y    = take ? pix_y : BLK_Y;
    take_c    = take ? pix_c : BLK_C;
    show_pix  = (seg == SEG_ACTIVE) && !vblank;

    case (code_idx)
      2'd0:    code_b = 8'hFF;
      2'd3:    code_b = trs_byte(field, vblank, seg == SEG_END);
      default: code_b = 8'h00;
    endcase

    hold_nx = y_hold;
    y_nx    = y_out;
    uv_nx   = uv_out;
    if (mode_r) begin
      uv_nx = 8'h00;
      if (show_pix) begin
        if (!phase) begin
          y_nx    = take_c;
          hold_nx = take_y;
        end else begin
          y_nx = y_hold;
        end
      end else if (seg == SEG_START || seg == SEG_END) begin
        y_nx = code_b;
      end else begin
        y_nx = phase ? BLK_Y : BLK_C;
      end
    end else begin
      if (show_pix) begin
        if (!phase) begin
          y_nx  = take_y;
          uv_nx = take_c;
        end
      end else begin
        y_nx  = BLK_Y;
        uv_nx = BLK_C;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out   <= BLK_Y;
      uv_out  <= BLK_C;
      y_hold  <= BLK_Y;
      cref    <= 1'b0;
      href    <= 1'b0;
      vsync   <= 1'b0;
      csync_n <= 1'b1;
    end else begin
      y_out   <= y_nx;
      uv_out  <= uv_nx;
      y_hold  <= hold_nx;
      cref    <= !phase;
      href    <= (seg == SEG_ACTIVE);
      vsync   <= vblank;
      csync_n <= !sync_low;
    end
  end

endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
  import vid_out_fmt_pkg::*;
#(
  parameter int NPIX       = 720,
  parameter int LINE_525   = 1716,
  parameter int LINE_625   = 1728,
  parameter int SOA_525    = 244,
  parameter int SOA_625    = 264,
  parameter int FIELD_525  = 262,
  parameter int FIELD_625  = 312,
  parameter int VBL_525    = 20,
  parameter int VBL_625    = 24,
  parameter int BROAD      = 3,
  parameter int SYNC_W     = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       std_625,
  input  logic       mode_8bit,
  input  logic       pix_valid,
  output logic       pix_ready,
  input  logic [7:0] pix_y,
  input  logic [7:0] pix_c,
  output logic [7:0] y_out,
  output logic [7:0] uv_out,
  output logic       cref,
  output logic       href,
  output logic       vsync,
  output logic       csync_n
);

  seg_t       seg;
  logic [1:0] code_idx;
  logic       phase, vblank, field, sync_low, mode_r;

  vid_out_timing #(
    .NPIX(NPIX), .LINE_525(LINE_525), .LINE_625(LINE_625),
    .SOA_525(SOA_525), .SOA_625(SOA_625),
    .FIELD_525(FIELD_525), .FIELD_625(FIELD_625),
    .VBL_525(VBL_525), .VBL_625(VBL_625),
    .BROAD(BROAD), .SYNC_W(SYNC_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .std_625(std_625), .mode_8bit(mode_8bit),
    .seg(seg), .code_idx(code_idx), .phase(phase), .vblank(vblank),
    .field(field), .sync_low(sync_low), .mode_r(mode_r)
  );

  vid_out_pixel u_pixel (
    .clk(clk), .rst_n(rst_n), .seg(seg), .code_idx(code_idx),
    .phase(phase), .vblank(vblank), .field(field), .sync_low(sync_low),
    .mode_r(mode_r), .pix_valid(pix_valid), .pix_y(pix_y), .pix_c(pix_c),
    .pix_ready(pix_ready), .y_out(y_out), .uv_out(uv_out), .cref(cref),
    .href(href), .vsync(vsync), .csync_n(csync_n)
  );

endmodule

// File: rtl/vid_out_fmt_chk.sv
module vid_out_fmt_chk #(
  parameter int NPIX = 720
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_ready,
  input logic [7:0] uv_out,
  input logic       cref,
  input logic       href,
  input logic       vsync,
  input logic       mode_r
);

  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (href) run <= run + 1;
    else run <= 0;
  end

  // R6
  cref_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cref |=> !cref);

  // R6
  cref_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cref && $past(rst_n)) |=> cref);

  // R9
  ready_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> href);

  // R9
  ready_not_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !vsync);

  // R2
  uv_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_r |=> (uv_out == 8'h00));

  // R3
  href_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(href) |-> (run == 2 * NPIX));

endmodule

bind vid_out_fmt vid_out_fmt_chk #(.NPIX(NPIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .uv_out(uv_out),
  .cref(cref), .href(href), .vsync(vsync), .mode_r(mode_r)
);

// File: tb/vid_out_fmt_bench.sv
`timescale 1ns/1ps
module vid_out_fmt_bench;

  localparam int NPIX = 8, L5 = 40, L6 = 44, S5 = 12, S6 = 14;
  localparam int F5 = 5, F6 = 6, V5 = 1, V6 = 2, BR = 1, SW = 4;

  logic clk = 0, rst_n = 0, std_625 = 0, mode_8bit = 0, pix_valid = 0;
  logic pix_ready, cref, href, vsync, csync_n;
  logic [7:0] pix_y = 0, pix_c = 0, y_out, uv_out;

  always #2 clk = ~clk;

  vid_out_fmt #(
    .NPIX(NPIX), .LINE_525(L5), .LINE_625(L6), .SOA_525(S5), .SOA_625(S6),
    .FIELD_525(F5), .FIELD_625(F6), .VBL_525(V5), .VBL_625(V6),
    .BROAD(BR), .SYNC_W(SW)
  ) u_vid_out_fmt (
    .clk(clk), .rst_n(rst_n), .std_625(std_625), .mode_8bit(mode_8bit),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_y(pix_y), .pix_c(pix_c),
    .y_out(y_out), .uv_out(uv_out), .cref(cref), .href(href), .vsync(vsync),
    .csync_n(csync_n)
  );

  int checks = 0, fails = 0, cyc = 0;
  int hc = 0, lc = 0, fld = 0, stdm = 0, modem = 0;
  int ey = 8'h10, euv = 8'h80, ehold = 8'h10, ehref = 0, evs = 0, ecs = 1, ecref = 0;
  string ytag = "R11", uvtag = "R11", ltag = "R11";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "y_out", y_out, 8'h10);
    chk("R11", "uv_out", uv_out, 8'h80);
    chk("R11", "href", href, 0);
    chk("R11", "vsync", vsync, 0);
    chk("R11", "cref", cref, 0);
    chk("R11", "csync_n", csync_n, 1);
    chk("R11", "pix_ready", pix_ready, 0);
    rst_n = 1;
    for (int k = 0; k < 2600; k++) begin
      int len, soa, fl, vbl, aend, v, hbit, ready, take, yb, cb;
      cyc = k;
      if (k > 0) begin
        chk(ytag, "y_out", y_out, ey);
        chk(uvtag, "uv_out", uv_out, euv);
        chk(ltag, "href", href, ehref);
        chk("R4", "vsync", vsync, evs);
        chk("R5", "csync_n", csync_n, ecs);
        chk("R6", "cref", cref, ecref);
      end
      // stimulus: standard/mode changes mid-frame, valid drops on a pattern
      if (k == 200) begin std_625 = 1; mode_8bit = 1; end
      if (k == 700) begin std_625 = 0; end
      if (k == 1300) begin std_625 = 1; mode_8bit = 0; end
      if (k == 1900) begin std_625 = 0; mode_8bit = 1; end
      pix_valid = ((k % 9) != 1) && ((k % 13) != 3);
      pix_y = 8'(8'h30 + k);
      pix_c = 8'(8'hC0 ^ k);
      #1;
      len = stdm ? L6 : L5; soa = stdm ? S6 : S5; fl = stdm ? F6 : F5;
      vbl = stdm ? V6 : V5; aend = soa + 2 * NPIX;
      v = (lc < vbl) ? 1 : 0;
      ready = (hc >= soa && hc < aend && (hc % 2) == 0 && !v) ? 1 : 0;
      chk("R9", "pix_ready", pix_ready, ready);
      take = ready && pix_valid;
      yb = take ? int'(pix_y) : 8'h10;
      cb = take ? int'(pix_c) : 8'h80;
      ltag = stdm ? "R10" : "R3";
      if (modem) begin
        euv = 0; uvtag = "R2";
        if (hc >= soa && hc < aend && !v) begin
          if (hc % 2 == 0) begin ey = cb; ehold = yb; ytag = take ? "R2" : "R9"; end
          else ey = ehold;
        end else if ((hc >= soa - 4 && hc < soa) || (hc >= aend && hc < aend + 4)) begin
          int i;
          i = (hc < soa) ? hc - (soa - 4) : hc - aend;
          hbit = (hc >= aend) ? 1 : 0;
          ytag = "R7";
          if (i == 0) ey = 8'hFF;
          else if (i == 3) ey = 128 + fld * 64 + v * 32 + hbit * 16 + (v ^ hbit) * 8 +
                                (fld ^ hbit) * 4 + (fld ^ v) * 2 + (fld ^ v ^ hbit);
          else ey = 0;
        end else begin
          ey = (hc % 2 == 0) ? 8'h80 : 8'h10; ytag = "R8";
        end
      end else begin
        if (hc >= soa && hc < aend && !v) begin
          if (hc % 2 == 0) begin ey = yb; euv = cb; ytag = take ? "R1" : "R9"; uvtag = ytag; end
        end else begin
          ey = 8'h10; euv = 8'h80; ytag = "R8"; uvtag = "R8";
        end
      end
      ehref = (hc >= soa && hc < aend) ? 1 : 0;
      evs = v;
      ecref = (hc % 2 == 0) ? 1 : 0;
      ecs = (lc < BR) ? ((hc < len - SW) ? 0 : 1) : ((hc < SW) ? 0 : 1);
      // advance model counters; sample standard and mode at frame end
      if (hc == len - 1) begin
        hc = 0;
        if (lc == fl - 1) begin
          lc = 0;
          if (fld == 1) begin stdm = int'(std_625); modem = int'(mode_8bit); end
          fld = 1 - fld;
        end else lc++;
      end else hc++;
      @(negedge clk);
    end
    finish_run();
  end

endmodule